// File: doc/BRIEF.md
# Power-Management Event Register Block

This block is the event and control side of a power-management controller. It holds a status register, an enable register and a control register, plus a free-running timer. All of them sit in a 64-byte I/O window. The window base comes from a configuration input, and a separate enable input switches decoding on or off. Three hardware event inputs, for a real-time-clock alarm, the power button and a global event, set their own status bits. The timer sets a fourth status bit each time its top bit changes.

An interrupt line stays high for as long as any status bit is set together with its matching enable bit. Software acknowledges an event by writing a 1 to that status bit. A write to the control register can also request a soft power-off, which appears as a one-cycle pulse on a shutdown output. Real suspend sequencing is left to the logic that receives this pulse.

Top module: `pmev_block`

## Requirements
- R1: While reset is high, and after it, all three registers and the timer read as zero, `sci` is low and `shutdown_req` is low.
- R2: The block decodes an access only when `win_en` is 1 and `io_addr[15:6]` equals `win_base_cfg[15:6]`; `win_base_cfg` bits 31:16 and 5:0 are ignored. Outside a decoded access, `io_rdata` is 0 and writes have no effect. The register offset is `io_addr[3:0]`, so the map repeats every 16 bytes within the window.
- R3: The read map is: offset 0x0 status, 0x2 enable, 0x4 control, 0x8 timer (zero-extended to 32 bits); every other offset reads 0. Writes to any offset other than 0x0, 0x2 and 0x4 have no effect.
- R4: All 16 bits of the enable register can be written and read back.
- R5: Status bit 0 is timer overflow, bit 5 is global (`ev_global`), bit 8 is power button (`ev_pwrbtn`) and bit 10 is RTC (`ev_rtc`). An event input that is high at a clock edge sets its bit. All other status bits always read 0.
- R6: A write to status clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R7: When an event sets a status bit in the same cycle that a write clears it, the bit ends up set.
- R8: `sci` is high exactly when, for at least one of bits 0, 5, 8 and 10, both the status bit and the enable bit are 1.
- R9: The timer is `TMR_W` bits wide. It increments by one every `TICK_DIV` clock cycles and wraps to zero.
- R10: The timer-overflow status bit sets at the clock edge where timer bit `TMR_W-1` changes value (in both directions, wrap included).
- R11: The control register stores the written value with bit 13 forced to 0.
- R12: A control write with bit 13 = 1 and bits 11:10 = 00 gives `shutdown_req` high for the one cycle after the write. A write with any other value in bits 11:10 gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| win_base_cfg | input | 32 | Window base; only bits 15:6 are used |
| win_en | input | 1 | Enables window decoding |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 32 | Read data for `io_addr` (combinational) |
| ev_rtc | input | 1 | RTC alarm event |
| ev_pwrbtn | input | 1 | Power-button event |
| ev_global | input | 1 | Global event |
| sci | output | 1 | Level interrupt |
| shutdown_req | output | 1 | One-cycle soft power-off request |

## Verification
The main same-cycle collision is a hardware event setting a status bit while software writes 1 to clear that same bit. A second collision is a timer top-bit change landing on a status-clear write. The bench provokes the first by holding the event inputs high during every status-clear pattern. It provokes the second by issuing clear writes all through a full timer wrap. In each cycle, the status, interrupt and shutdown values are judged against a bench model that applies sets after clears.

// File: rtl/pmev_pkg.sv
package pmev_pkg;

    localparam logic [15:0] WIN_MASK = 16'hFFC0;

    localparam int STS_TMR = 0;
    localparam int STS_GLB = 5;
    localparam int STS_PWR = 8;
    localparam int STS_RTC = 10;

    localparam logic [15:0] EVT_MASK = (16'h1 << STS_TMR) | (16'h1 << STS_GLB) |
                                       (16'h1 << STS_PWR) | (16'h1 << STS_RTC);

    localparam int CTL_SUS_EN = 13;
    localparam int CTL_TYP_HI = 11;
    localparam int CTL_TYP_LO = 10;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STS,
        SEL_EN,
        SEL_CTL,
        SEL_TMR
    } reg_sel_e;

    typedef struct packed {
        logic        wr;
        reg_sel_e    sel;
        logic [15:0] data;
    } io_req_t;

    typedef struct packed {
        logic rtc;
        logic pwr;
        logic glb;
        logic tmr;
    } evt_t;

    function automatic reg_sel_e sel_of(input logic [3:0] off);
        case (off)
            4'h0:    return SEL_STS;
            4'h2:    return SEL_EN;
            4'h4:    return SEL_CTL;
            4'h8:    return SEL_TMR;
            default: return SEL_NONE;
        endcase
    endfunction

    function automatic logic [15:0] evt_vec(input evt_t e);
        logic [15:0] v;
        v          = '0;
        v[STS_TMR] = e.tmr;
        v[STS_GLB] = e.glb;
        v[STS_PWR] = e.pwr;
        v[STS_RTC] = e.rtc;
        return v;
    endfunction

endpackage

// File: rtl/pmev_decode.sv
module pmev_decode
    import pmev_pkg::*;
(
    input  logic [15:0] io_addr,
    input  logic [31:0] win_base_cfg,
    input  logic        win_en,
    input  logic        io_wr,
    input  logic [15:0] io_wdata,
    output io_req_t     req
);
    logic [15:0] base;
    logic        hit;
    logic        cfg_unused;

    assign base       = win_base_cfg[15:0] & WIN_MASK;
    assign hit        = win_en && ((io_addr & WIN_MASK) == base);
    assign cfg_unused = ^win_base_cfg[31:16];

    always_comb begin
        req.wr   = io_wr && hit;
        req.sel  = hit ? sel_of(io_addr[3:0]) : SEL_NONE;
        req.data = io_wdata;
    end
endmodule

// File: rtl/pmev_timer.sv
module pmev_timer #(
    parameter int TICK_DIV = 4,
    parameter int TMR_W    = 24
) (
    input  logic             clk,
    input  logic             rst,
    output logic [TMR_W-1:0] count,
    output logic             ovf_evt
);
    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

    logic [PRE_W-1:0] pre;
    logic             tick;
    logic [TMR_W-1:0] count_nxt;

    assign tick      = (pre == PRE_LAST);
    assign count_nxt = count + 1'b1;
    assign ovf_evt   = tick && (count_nxt[TMR_W-1] != count[TMR_W-1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre   <= '0;
            count <= '0;
        end else if (tick) begin
            pre   <= '0;
            count <= count_nxt;
        end else begin
            pre   <= pre + 1'b1;
        end
    end

    // R9
    tmr_step_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> (count == TMR_W'($past(count) + 1'b1)));

    // R9
    tmr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count));
endmodule

// File: rtl/pmev_regs.sv
module pmev_regs
    import pmev_pkg::*;
#(
    parameter int TMR_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  io_req_t          req,
    input  evt_t             evt,
    input  logic [TMR_W-1:0] tmr,
    output logic [31:0]      rdata,
    output logic             sci,
    output logic             shutdown_req
);
    logic [15:0] sts;
    logic [15:0] en;
    logic [15:0] ctl;
    logic [15:0] set_vec;
    logic [15:0] clr_vec;
    logic        wr_ctl;
    logic        soft_off;

    assign set_vec  = evt_vec(evt);
    assign clr_vec  = (req.wr && req.sel == SEL_STS) ? req.data : 16'h0;
    assign wr_ctl   = req.wr && req.sel == SEL_CTL;
    assign soft_off = wr_ctl && req.data[CTL_SUS_EN] &&
                      (req.data[CTL_TYP_HI:CTL_TYP_LO] == 2'b00);

    always_ff @(posedge clk) begin
        if (rst) begin
            sts          <= '0;
            en           <= '0;
            ctl          <= '0;
            shutdown_req <= 1'b0;
        end else begin
            sts          <= ((sts & ~clr_vec) | set_vec) & EVT_MASK;
            shutdown_req <= soft_off;
            if (req.wr && req.sel == SEL_EN) en <= req.data;
            if (wr_ctl) begin
                ctl             <= req.data;
                ctl[CTL_SUS_EN] <= 1'b0;
            end
        end
    end

    always_comb begin
        case (req.sel)
            SEL_STS: rdata = {16'h0, sts};
            SEL_EN:  rdata = {16'h0, en};
            SEL_CTL: rdata = {16'h0, ctl};
            SEL_TMR: rdata = 32'(tmr);
            default: rdata = 32'h0;
        endcase
    end

    assign sci = |(sts & en & EVT_MASK);

    // R5
    sts_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
        ((sts & ~EVT_MASK) == 16'h0));

    // R6
    sts_w1c_chk: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.sel == SEL_STS && set_vec == 16'h0) |=>
        ((sts & $past(req.data)) == 16'h0));

    // R7
    sts_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (set_vec != 16'h0) |=> ((sts & $past(set_vec)) == $past(set_vec)));

    // R10
    tmr_sts_chk: assert property (@(posedge clk) disable iff (rst)
        evt.tmr |=> sts[STS_TMR]);

    // R12
    soft_off_type_chk: assert property (@(posedge clk) disable iff (rst)
        shutdown_req |-> (ctl[CTL_TYP_HI:CTL_TYP_LO] == 2'b00 && !ctl[CTL_SUS_EN]));
endmodule

// File: rtl/pmev_block.sv
module pmev_block
    import pmev_pkg::*;
#(
    parameter int TICK_DIV = 4,
    parameter int TMR_W    = 24
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] win_base_cfg,
    input  logic        win_en,
    input  logic [15:0] io_addr,
    input  logic        io_wr,
    input  logic [15:0] io_wdata,
    output logic [31:0] io_rdata,
    input  logic        ev_rtc,
    input  logic        ev_pwrbtn,
    input  logic        ev_global,
    output logic        sci,
    output logic        shutdown_req
);
    io_req_t          req;
    evt_t             evt;
    logic [TMR_W-1:0] tmr;
    logic             tmr_ovf;

    pmev_decode u_decode (
        .io_addr      (io_addr),
        .win_base_cfg (win_base_cfg),
        .win_en       (win_en),
        .io_wr        (io_wr),
        .io_wdata     (io_wdata),
        .req          (req)
    );

    pmev_timer #(.TICK_DIV(TICK_DIV), .TMR_W(TMR_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .count   (tmr),
        .ovf_evt (tmr_ovf)
    );

    always_comb begin
        evt.rtc = ev_rtc;
        evt.pwr = ev_pwrbtn;
        evt.glb = ev_global;
        evt.tmr = tmr_ovf;
    end

    pmev_regs #(.TMR_W(TMR_W)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .req          (req),
        .evt          (evt),
        .tmr          (tmr),
        .rdata        (io_rdata),
        .sci          (sci),
        .shutdown_req (shutdown_req)
    );

    // R2
    win_off_chk: assert property (@(posedge clk) disable iff (rst)
        !win_en |-> (io_rdata == 32'h0));
endmodule

// File: tb/pmev_block_tb_top.sv
module pmev_block_tb_top;
    localparam int TW = 8;
    localparam int TD = 2;
    localparam logic [15:0] EVM = 16'h0521;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] win_base_cfg = 32'hABCD_B07F;
    logic        win_en = 1'b1;
    logic [15:0] io_addr = 16'hB040;
    logic        io_wr = 1'b0;
    logic [15:0] io_wdata = 16'h0;
    logic [31:0] io_rdata;
    logic        ev_rtc = 1'b0, ev_pwrbtn = 1'b0, ev_global = 1'b0;
    logic        sci, shutdown_req;

    always #2 clk = ~clk;

    pmev_block #(.TICK_DIV(TD), .TMR_W(TW)) dut_i (
        .clk(clk), .rst(rst), .win_base_cfg(win_base_cfg), .win_en(win_en),
        .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .ev_rtc(ev_rtc), .ev_pwrbtn(ev_pwrbtn), .ev_global(ev_global),
        .sci(sci), .shutdown_req(shutdown_req)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    string tag = "R1";
    bit    done = 1'b0;

    // Reference model, built from the requirements
    logic [15:0] m_sts = '0, m_en = '0, m_ctl = '0;
    logic        m_sd = 1'b0;
    int          m_n = 0;

    function automatic int tmr_at(int e);
        return (e / TD) % (1 << TW);
    endfunction

    function automatic bit hit_now();
        return win_en && (io_addr[15:6] == win_base_cfg[15:6]);
    endfunction

    always @(posedge clk) begin : model
        int          nn;
        logic [15:0] setv, clrv;
        bit          w;
        if (rst) begin
            m_sts <= '0; m_en <= '0; m_ctl <= '0; m_sd <= 1'b0; m_n <= 0;
        end else begin
            nn = m_n + 1;
            setv = '0;
            setv[0]  = ((tmr_at(nn) >> (TW-1)) & 1) != ((tmr_at(m_n) >> (TW-1)) & 1);
            setv[5]  = ev_global;
            setv[8]  = ev_pwrbtn;
            setv[10] = ev_rtc;
            w = hit_now() && io_wr;
            clrv = (w && io_addr[3:0] == 4'h0) ? io_wdata : 16'h0;
            m_sts <= ((m_sts & ~clrv) | setv) & EVM;
            if (w && io_addr[3:0] == 4'h2) m_en <= io_wdata;
            if (w && io_addr[3:0] == 4'h4) m_ctl <= io_wdata & ~16'h2000;
            m_sd <= w && io_addr[3:0] == 4'h4 && io_wdata[13] && io_wdata[11:10] == 2'b00;
            m_n <= nn;
        end
    end

    function automatic logic [31:0] exp_rd();
        if (!hit_now()) return 32'h0;
        case (io_addr[3:0])
            4'h0: return {16'h0, m_sts};
            4'h2: return {16'h0, m_en};
            4'h4: return {16'h0, m_ctl};
            4'h8: return 32'(tmr_at(m_n));
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
        check("sci", 32'(sci), 32'(|(m_sts & m_en & EVM)));
        check("shutdown_req", 32'(shutdown_req), 32'(m_sd));
        check("io_rdata", io_rdata, exp_rd());
    endtask

    task automatic wr_a(logic [15:0] a, logic [15:0] d);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        cyc();
        io_wr = 1'b0;
    endtask

    task automatic rd_a(logic [15:0] a);
        io_addr = a;
        cyc();
    endtask

    task automatic wr(logic [3:0] off, logic [15:0] d);
        wr_a({win_base_cfg[15:6], 2'b00, off}, d);
    endtask

    task automatic rd(logic [3:0] off);
        rd_a({win_base_cfg[15:6], 2'b00, off});
    endtask

    function automatic logic [15:0] spread(logic [3:0] m);
        logic [15:0] v = '0;
        v[0] = m[0]; v[5] = m[1]; v[8] = m[2]; v[10] = m[3];
        return v;
    endfunction

    task automatic pulse(logic [2:0] e);
        ev_global = e[0]; ev_pwrbtn = e[1]; ev_rtc = e[2];
        cyc();
        ev_global = 1'b0; ev_pwrbtn = 1'b0; ev_rtc = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        // R1: reset state, reads of every register while reset is held
        tag = "R1";
        for (int o = 0; o < 16; o += 2) rd(4'(o));
        rst = 1'b0;
        rd(0); rd(2); rd(4); rd(8);

        // R4: enable read/write sweep
        tag = "R4";
        for (int i = 0; i < 16; i++) begin wr(2, 16'(1 << i)); rd(2); end
        for (int v = 0; v < 256; v++) begin wr(2, 16'(v * 257) ^ 16'h5A3C); rd(2); end

        // R11: control storage with bit 13 masked
        tag = "R11";
        for (int v = 0; v < 64; v++) begin wr(4, 16'(v * 1031) | 16'h2C00); rd(4); end
        wr(4, 16'hDFFF); rd(4);

        // R12: shutdown pulse only for suspend type 0
        tag = "R12";
        for (int t = 0; t < 4; t++)
            for (int s = 0; s < 2; s++) begin
                wr(4, 16'((s << 13) | (t << 10) | 16'h0283));
                rd(4); rd(4);
            end
        wr(4, 16'h2000); wr(4, 16'h2000); rd(4);

        // R3: read map, and writes to unmapped offsets
        tag = "R3";
        wr(2, 16'hBEEF);
        for (int o = 0; o < 16; o++) rd(4'(o));
        wr(8, 16'hFFFF); wr(6, 16'h1234); wr(4'hE, 16'h4321); wr(1, 16'hFFFF);
        for (int o = 0; o < 16; o++) rd(4'(o));

        // R5 / R6: event sets, then every clear pattern
        tag = "R6";
        wr(2, 16'h0);
        for (int e = 0; e < 8; e++)
            for (int m = 0; m < 16; m++) begin
                wr(0, 16'hFFFF);
                pulse(3'(e));
                rd(0);
                wr(0, spread(4'(m)) | 16'hFADE);
                rd(0);
            end
        tag = "R5";
        for (int e = 0; e < 8; e++) begin wr(0, 16'hFFFF); pulse(3'(e)); rd(0); end

        // R7: event held during the clearing write
        tag = "R7";
        for (int e = 0; e < 8; e++)
            for (int m = 0; m < 16; m++) begin
                ev_global = e[0]; ev_pwrbtn = e[1]; ev_rtc = e[2];
                wr(0, spread(4'(m)));
                ev_global = 1'b0; ev_pwrbtn = 1'b0; ev_rtc = 1'b0;
                rd(0);
            end

        // R8: interrupt over every enable/status combination
        tag = "R8";
        for (int en = 0; en < 16; en++)
            for (int e = 0; e < 8; e++) begin
                wr(0, 16'hFFFF);
                wr(2, spread(4'(en)) | 16'h8002);
                pulse(3'(e));
                rd(0);
            end

        // R9: timer value over a full wrap and more
        tag = "R9";
        rd(8);
        repeat (2 * TD * (1 << TW) + 8) cyc();

        // R10: overflow status, clear writes running through the toggles
        tag = "R10";
        wr(2, 16'h0001);
        for (int i = 0; i < 4 * TD * (1 << TW); i++) begin
            if (i % 37 == 0) wr(0, 16'h0001);
            else rd(0);
        end

        // R2: window enable, base masking, aliasing
        tag = "R2";
        wr(2, 16'h00F0);
        win_en = 1'b0;
        rd(2); wr(2, 16'h1111); wr(4, 16'h2000);
        win_en = 1'b1;
        rd(2);
        wr_a(16'hB082, 16'h2222); rd_a(16'hB082); rd(2);
        rd_a(16'hB052); rd_a(16'hB072);
        wr_a(16'hB072, 16'h7777); rd(2); rd_a(16'hB062);
        win_base_cfg = 32'h5555_1FFF;
        rd_a(16'hB042); rd_a(16'h1FC2); wr_a(16'h1FE2, 16'h0505); rd_a(16'h1FC2);
        rd_a(16'h1FC8);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule